// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external controller reach a bank of byte-wide configuration registers over a four-wire serial link. A transaction opens when the chip select goes low. The first byte is an opcode, the second is a start address, and every further byte is data moving in or out. While the select stays low the address steps forward after each data byte, so one opcode can sweep the whole bank. After the last register the address returns to zero.

The serial pins are sampled by the system clock through synchronizer stages. The serial clock must therefore run well below the system clock; at least eight system cycles per half period is a safe ratio. The register bank sits inside the block. On-chip logic reads it through a parallel port with a registered output. The data output pin has a separate drive enable so that a pad can release the line.

Top module: `spi_cfg_slave`

## Requirements
- R1: Opcode 0x03 starts a read and opcode 0x02 starts a write. The byte after the opcode is the start address. Bits move most significant first, input is taken on the rising serial clock edge and output changes after the falling edge.
- R2: In a write, each complete data byte is stored at the current address, and the address then advances by one for the next byte.
- R3: In a read, the first data byte is the register at the start address and is presented right after the address byte. Each later byte is the register at the next address, with no new opcode.
- R4: The address that follows the highest register (DEPTH-1, 197 by default) is 0, for reads and for writes.
- R5: A start address of DEPTH or above reads as 0x00 and ignores writes. The address that follows it is 0.
- R6: Raising chip select drops a partly shifted byte without storing it. The next transaction starts again with an opcode byte.
- R7: Any other opcode causes no write for the rest of the transaction, and the data output stays low until chip select rises.
- R8: The output enable is high while the block is selected and low once chip select has been high for three system clocks. During the opcode and address bytes of a read, the data output is low.
- R9: The parallel port shows the register at host_raddr one clock after the address is applied, and shows 0x00 for an address of DEPTH or above.
- R10: During reset the output enable is low and host_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block |
| spi_sdo_oe | output | 1 | Drive enable for the serial output pad |
| host_raddr | input | 8 | Parallel read address |
| host_rdata | output | 8 | Parallel read data, registered |

## Verification
A full write sweep starts inside the bank and runs past its end. This separates correct wrapping from linear overflow and loads a distinct value into every register. Read sweeps that cross the top address, and a single read of a freshly written register, then show whether the output follows the counter or stalls on one byte. Starting addresses past the bank, an opcode that is not recognised, and a select that rises in the middle of a byte each test a different way of rejecting data. The effect of each is checked afterwards through the parallel port or through a later read.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 8;

  localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_RADDR,
    PH_WADDR,
    PH_RDATA,
    PH_WDATA,
    PH_SKIP
  } phase_e;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              tx_en,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rise;
  logic              fall;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      byte_done <= 1'b0;
      sdo_oe    <= sel;
      if (!sel) begin
        bit_cnt <= '0;
        sdo     <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], sdi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[BYTE_W-2:0], sdi_s};
          end
        end
        if (!tx_en) begin
          sdo <= 1'b0;
        end else if (fall) begin
          if (bit_cnt == '0) begin
            sdo   <= tx_byte[BYTE_W-1];
            tx_sh <= {tx_byte[BYTE_W-2:0], 1'b0};
          end else begin
            sdo   <= tx_sh[BYTE_W-1];
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DEPTH = 198
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output phase_e            phase,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              adv,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [ADDR_W-1:0] nxt_addr;

  assign nxt_addr = (int'(cur_addr) >= LAST) ? '0 : cur_addr + 1'b1;
  assign adv      = sel && byte_done && (phase == PH_RDATA || phase == PH_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      cur_addr <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (!sel) begin
        phase <= PH_CMD;
      end else if (byte_done) begin
        case (phase)
          PH_CMD: begin
            if (rx_byte == OPC_READ)       phase <= PH_RADDR;
            else if (rx_byte == OPC_WRITE) phase <= PH_WADDR;
            else                           phase <= PH_SKIP;
          end
          PH_RADDR: begin
            cur_addr <= rx_byte;
            rd_en    <= 1'b1;
            rd_addr  <= rx_byte;
            phase    <= PH_RDATA;
          end
          PH_WADDR: begin
            cur_addr <= rx_byte;
            phase    <= PH_WDATA;
          end
          PH_RDATA: begin
            cur_addr <= nxt_addr;
            rd_en    <= 1'b1;
            rd_addr  <= nxt_addr;
          end
          PH_WDATA: begin
            wr_en    <= int'(cur_addr) < DEPTH;
            wr_addr  <= cur_addr;
            wr_data  <= rx_byte;
            cur_addr <= nxt_addr;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DEPTH = 198
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [BYTE_W-1:0] a_wdata,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [BYTE_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [BYTE_W-1:0] b_rdata
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] a_raw;
  logic [BYTE_W-1:0] b_raw;
  logic              a_ok;
  logic              b_ok;

  always_ff @(posedge clk) begin
    if (a_we) mem[a_waddr[IDX_W-1:0]] <= a_wdata;
    if (a_re) a_raw <= mem[a_raddr[IDX_W-1:0]];
    b_raw <= mem[b_addr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_ok <= 1'b0;
      b_ok <= 1'b0;
    end else begin
      if (a_re) a_ok <= int'(a_raddr) < DEPTH;
      b_ok <= int'(b_addr) < DEPTH;
    end
  end

  assign a_rdata = a_ok ? a_raw : '0;
  assign b_rdata = b_ok ? b_raw : '0;

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DEPTH       = 198,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [BYTE_W-1:0] host_rdata
);

  logic [2:0]        pins_s;
  logic              sel;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] tx_byte;
  phase_e            phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              adv;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;

  spi_cfg_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({spi_cs_n, spi_sclk, spi_sdi}),
    .d_out (pins_s)
  );

  assign sel = ~pins_s[2];

  spi_cfg_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .tx_en     (phase == PH_RDATA),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe)
  );

  spi_cfg_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .phase     (phase),
    .cur_addr  (cur_addr),
    .adv       (adv),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
  );

  spi_cfg_regbank #(
    .DEPTH (DEPTH)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .a_we    (wr_en),
    .a_waddr (wr_addr),
    .a_wdata (wr_data),
    .a_re    (rd_en),
    .a_raddr (rd_addr),
    .a_rdata (tx_byte),
    .b_addr  (host_raddr),
    .b_rdata (host_rdata)
  );

endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DEPTH = 198
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_sdo,
  input logic              spi_sdo_oe,
  input logic [ADDR_W-1:0] host_raddr,
  input logic [BYTE_W-1:0] host_rdata,
  input phase_e            phase,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              adv,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_sdo_oe);

  // R8
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !$past(spi_cs_n) && !$past(spi_cs_n, 2) && !$past(spi_cs_n, 3)) |-> spi_sdo_oe);

  // R7
  skip_low_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |=> !spi_sdo);

  // R7
  skip_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |=> !wr_en);

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < DEPTH));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && int'(cur_addr) >= DEPTH - 1) |=> (cur_addr == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && int'(cur_addr) < DEPTH - 1) |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R9
  host_oor_chk: assert property (@(posedge clk) disable iff (rst)
    (int'($past(host_raddr)) >= DEPTH) |-> (host_rdata == '0));

endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .spi_cs_n   (spi_cs_n),
  .spi_sdo    (spi_sdo),
  .spi_sdo_oe (spi_sdo_oe),
  .host_raddr (host_raddr),
  .host_rdata (host_rdata),
  .phase      (phase),
  .cur_addr   (cur_addr),
  .adv        (adv),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr)
);

// File: tb/test_spi_cfg_slave.sv
`timescale 1ns/1ps
module test_spi_cfg_slave;

  localparam int DEPTH = 198;
  localparam int HALF  = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       spi_cs_n, spi_sclk, spi_sdi;
  logic       spi_sdo, spi_sdo_oe;
  logic [7:0] host_raddr;
  logic [7:0] host_rdata;

  always #4 clk = ~clk;

  spi_cfg_slave #(.DEPTH(DEPTH)) i_spi_cfg_slave (
    .clk        (clk),
    .rst        (rst),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_sdi    (spi_sdi),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata)
  );

  int         n_run  = 0;
  int         n_fail = 0;
  logic [7:0] model  [DEPTH];
  logic [7:0] tx_buf [256];
  logic [7:0] rx_buf [256];
  logic       oe_mid;
  bit         finished = 0;

  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Monitor: compares received bytes against expected items in order
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(g), int'(e));
      end
    end
  end

  task automatic wait_clk(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_byte(logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic spi_xfer(int n, int tail);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n + ((tail > 0) ? 1 : 0); i++) begin
      int nb;
      logic [7:0] r;
      nb = (i < n) ? 8 : tail;
      r  = 8'h00;
      for (int b = 0; b < nb; b++) begin
        spi_sdi = tx_buf[i][7-b];
        wait_clk(HALF);
        r = {r[6:0], spi_sdo};
        if (i == 0 && b == 4) oe_mid = spi_sdo_oe;
        spi_sclk = 1'b1;
        wait_clk(HALF);
        spi_sclk = 1'b0;
      end
      rx_buf[i] = r;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic push_rx(int n);
    for (int i = 0; i < n; i++) got_q.push_back(rx_buf[i]);
  endtask

  task automatic host_check(logic [7:0] a, logic [7:0] e, string tag);
    host_raddr = a;
    wait_clk(2);
    check(tag, int'(host_rdata), int'(e));
  endtask

  function automatic int nxt(int a);
    return (a >= DEPTH - 1) ? 0 : a + 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int a;
    rst = 1'b1; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_sdi = 1'b0;
    host_raddr = 8'd0;
    wait_clk(4);
    check("R10 oe in reset", int'(spi_sdo_oe), 0);
    check("R10 host_rdata in reset", int'(host_rdata), 0);
    rst = 1'b0;
    wait_clk(4);

    // R2 R4: full write sweep from 5, wraps past 197 to 0..4
    tx_buf[0] = 8'h02; tx_buf[1] = 8'd5;
    a = 5;
    for (int i = 0; i < DEPTH; i++) begin
      tx_buf[2+i] = 8'((i * 37 + 11) & 255);
      model[a] = tx_buf[2+i];
      a = nxt(a);
    end
    spi_xfer(DEPTH + 2, 0);
    check("R8 oe while selected", int'(oe_mid), 1);
    check("R8 oe after deselect", int'(spi_sdo_oe), 0);
    host_check(8'd5,   model[5],   "R2 first write");
    host_check(8'd6,   model[6],   "R2 second write");
    host_check(8'd197, model[197], "R4 top register");
    host_check(8'd0,   model[0],   "R4 wrapped write");
    host_check(8'd4,   model[4],   "R4 last of sweep");
    host_check(8'd230, 8'h00,      "R9 out of range host read");

    // R1: single write then single read
    tx_buf[0] = 8'h02; tx_buf[1] = 8'd100; tx_buf[2] = 8'hC3;
    spi_xfer(3, 0);
    model[100] = 8'hC3;
    tx_buf[0] = 8'h03; tx_buf[1] = 8'd100; tx_buf[2] = 8'h00;
    spi_xfer(3, 0);
    expect_byte(8'h00, "R8 sdo low in opcode");
    expect_byte(8'h00, "R8 sdo low in address");
    expect_byte(8'hC3, "R1 single read");
    push_rx(3);

    // R3 R4: read burst crossing the top
    tx_buf[0] = 8'h03; tx_buf[1] = 8'd190;
    for (int i = 2; i < 24; i++) tx_buf[i] = 8'h00;
    spi_xfer(24, 0);
    expect_byte(8'h00, "R8 opcode phase");
    expect_byte(8'h00, "R8 address phase");
    a = 190;
    for (int i = 0; i < 22; i++) begin
      expect_byte(model[a], (a < 190) ? "R4 read wrap" : "R3 read burst");
      a = nxt(a);
    end
    push_rx(24);

    // R5: read from beyond the bank
    tx_buf[0] = 8'h03; tx_buf[1] = 8'd250; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    spi_xfer(4, 0);
    expect_byte(8'h00, "R5 opcode");
    expect_byte(8'h00, "R5 address");
    expect_byte(8'h00, "R5 out of range reads zero");
    expect_byte(model[0], "R5 next address is zero");
    push_rx(4);

    // R5: write beyond the bank is dropped, next byte goes to 0
    tx_buf[0] = 8'h02; tx_buf[1] = 8'd210; tx_buf[2] = 8'hAA; tx_buf[3] = 8'h55;
    spi_xfer(4, 0);
    model[0] = 8'h55;
    host_check(8'd0, 8'h55, "R5 write after out of range lands at 0");
    tx_buf[0] = 8'h03; tx_buf[1] = 8'd210; tx_buf[2] = 8'h00;
    spi_xfer(3, 0);
    check("R5 out of range write ignored", int'(rx_buf[2]), 0);

    // R6: partial byte dropped
    tx_buf[0] = 8'h02; tx_buf[1] = 8'd10; tx_buf[2] = 8'h77; tx_buf[3] = 8'h99;
    spi_xfer(3, 5);
    model[10] = 8'h77;
    host_check(8'd11, model[11], "R6 partial byte not stored");
    tx_buf[0] = 8'h03; tx_buf[1] = 8'd10; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
    spi_xfer(4, 0);
    expect_byte(8'h00, "R6 fresh opcode");
    expect_byte(8'h00, "R6 fresh address");
    expect_byte(8'h77, "R6 full byte kept");
    expect_byte(model[11], "R6 neighbour intact");
    push_rx(4);

    // R7: unknown opcode
    tx_buf[0] = 8'h0B; tx_buf[1] = 8'd20; tx_buf[2] = 8'hFF; tx_buf[3] = 8'hFF;
    spi_xfer(4, 0);
    for (int i = 0; i < 4; i++) expect_byte(8'h00, "R7 sdo low");
    push_rx(4);
    host_check(8'd20, model[20], "R7 no write");
    host_check(8'd21, model[21], "R7 no write next");

    wait_clk(20);
    check("R1 scoreboard drained", got_q.size() + exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule